// File: doc/BRIEF.md
# Programmable Vertical Display Start Detector

This block finds the first scan line of two independent on-screen display regions. After each frame event on the vertical sync input, it counts the active edges of the horizontal sync input. For each region it compares the running line number against a programmable start line. When the count reaches that line, it raises a one-clock start pulse and then holds a level flag until the next frame event.

Each sync input has its own polarity bit, and that bit chooses whether rising or falling edges are active. Both inputs pass through a two-flop synchroniser. Edges are sampled on a machine-cycle enable that occurs once every four system clocks. A horizontal edge that arrives too close to the frame event is ignored, so that a near-coincident edge cannot cause jitter. Software loads the two 8-bit start registers through a simple write strobe. A value is copied into a per-region shadow on each frame event, so a write takes effect from the next frame. The start line is a fixed offset of 17 plus the register value. A value of zero keeps the region switched off.

Top module: `vstart_detect`

## Requirements
- R1: With a polarity bit at 0 the rising edge of that sync input is active; at 1 the falling edge is active. This holds independently for the horizontal and vertical inputs.
- R2: Line counting restarts at zero on each active vertical edge. A horizontal active edge sampled on the same machine cycle as that vertical edge, or on either of the 2 machine cycles that follow it, is not counted.
- R3: With a nonzero register value n, the region's start pulse is raised on the (17+n)-th counted horizontal edge of the frame.
- R4: Region 0 (wr_sel=0) and region 1 (wr_sel=1) each compare against their own register, independently of each other.
- R5: A register value of 0 disables the region: it never raises a start pulse or its active flag. Both registers read as 0 after reset.
- R6: Each start pulse lasts exactly one system clock. The active flag rises together with the pulse and stays high until the next active vertical edge, which clears it.
- R7: The line count stops at 272 (17+255). Further horizontal edges in the same frame raise no further pulse.
- R8: A register write in mid-frame does not change the current frame's start line. It takes effect at the next active vertical edge.
- R9: After reset, both start pulses and both active flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hs_in | input | 1 | Raw horizontal sync |
| vs_in | input | 1 | Raw vertical sync |
| hs_pol_neg | input | 1 | 1 selects falling edges of hs_in as active |
| vs_pol_neg | input | 1 | 1 selects falling edges of vs_in as active |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Region register selected by the write |
| wr_data | input | 8 | Start value to write |
| start_pulse | output | 2 | One-clock start pulse per region |
| region_act | output | 2 | Region active flag per region |

## Verification
A wrong line count, a mis-set guard window or a stale shadow value would show at the ports as a start pulse one or more scan lines early or late. At a line period of 64 clocks, that means the pulse is tens of clocks away from the cycle the reference model predicts. A wrong edge selection or a flaw in clearing the flag shows within one machine cycle of the offending sync edge. At that point, region_act or start_pulse differ from the model on the very next compared clock. The bench also checks, frame by frame, the line index at which each pulse occurs against 17+n.

// File: rtl/vsd_pkg.sv
package vsd_pkg;
    localparam int LINE_OFFSET = 17;
    localparam int GUARD_MC    = 2;

    typedef struct packed {
        logic       prev;
        logic [1:0] sync;
    } edge_state_t;
endpackage

// File: rtl/vsd_sync_edge.sv
module vsd_sync_edge
    import vsd_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic raw_i,
    input  logic pol_neg_i,
    input  logic ce_i,
    output logic edge_o
);
    edge_state_t st_q, st_d;
    logic        lvl;

    always_comb begin
        st_d      = st_q;
        st_d.sync = {st_q.sync[0], raw_i};
        lvl       = st_q.sync[1] ^ pol_neg_i;
        edge_o    = ce_i & lvl & ~st_q.prev;
        if (ce_i) st_d.prev = lvl;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R1
    edge_on_ce_chk: assert property (@(posedge clk) disable iff (!rst_n)
        edge_o |-> ce_i);
endmodule

// File: rtl/vsd_line_counter.sv
module vsd_line_counter
    import vsd_pkg::*;
#(
    parameter int CNT_W   = 9,
    parameter int CNT_MAX = 272
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ce_i,
    input  logic             vs_edge_i,
    input  logic             hs_edge_i,
    output logic             tick_o,
    output logic [CNT_W-1:0] line_o
);
    localparam int GW = $clog2(GUARD_MC + 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [GW-1:0]    guard;
    } cnt_state_t;

    cnt_state_t st_q, st_d;

    always_comb begin
        st_d   = st_q;
        tick_o = 1'b0;
        if (vs_edge_i) begin
            st_d.cnt   = '0;
            st_d.guard = GW'(GUARD_MC);
        end else begin
            if (ce_i && st_q.guard != '0) st_d.guard = st_q.guard - 1'b1;
            if (hs_edge_i && st_q.guard == '0 && st_q.cnt < CNT_W'(CNT_MAX)) begin
                tick_o   = 1'b1;
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
        line_o = st_d.cnt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R7
    cnt_ceiling_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= CNT_W'(CNT_MAX));

    // R2
    frame_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vs_edge_i |=> st_q.cnt == '0);
endmodule

// File: rtl/vsd_region.sv
module vsd_region
    import vsd_pkg::*;
#(
    parameter int POS_W = 8,
    parameter int CNT_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_hit_i,
    input  logic [POS_W-1:0] wr_data_i,
    input  logic             vs_edge_i,
    input  logic             tick_i,
    input  logic [CNT_W-1:0] line_i,
    output logic             pulse_o,
    output logic             act_o
);
    typedef struct packed {
        logic [POS_W-1:0] pos;
        logic [POS_W-1:0] shadow;
        logic             pulse;
        logic             act;
    } reg_state_t;

    reg_state_t st_q, st_d;
    logic       hit;

    always_comb begin
        st_d       = st_q;
        st_d.pulse = 1'b0;
        hit        = tick_i && (st_q.shadow != '0) &&
                     (line_i == CNT_W'(LINE_OFFSET) + CNT_W'(st_q.shadow));
        if (vs_edge_i) begin
            st_d.shadow = st_q.pos;
            st_d.act    = 1'b0;
        end else if (hit) begin
            st_d.pulse = 1'b1;
            st_d.act   = 1'b1;
        end
        if (wr_hit_i) st_d.pos = wr_data_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pulse_o = st_q.pulse;
    assign act_o   = st_q.act;

    // R6
    pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.pulse |=> !st_q.pulse);

    // R6
    pulse_sets_act_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.pulse |-> st_q.act);

    // R5
    zero_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.pulse |-> st_q.shadow != '0);
endmodule

// File: rtl/vstart_detect.sv
module vstart_detect
    import vsd_pkg::*;
#(
    parameter int NUM_REGIONS = 2,
    parameter int POS_W       = 8,
    parameter int MC_DIV      = 4,
    localparam int SEL_W      = (NUM_REGIONS > 1) ? $clog2(NUM_REGIONS) : 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   hs_in,
    input  logic                   vs_in,
    input  logic                   hs_pol_neg,
    input  logic                   vs_pol_neg,
    input  logic                   wr_en,
    input  logic [SEL_W-1:0]       wr_sel,
    input  logic [POS_W-1:0]       wr_data,
    output logic [NUM_REGIONS-1:0] start_pulse,
    output logic [NUM_REGIONS-1:0] region_act
);
    localparam int CNT_MAX = LINE_OFFSET + (1 << POS_W) - 1;
    localparam int CNT_W   = $clog2(CNT_MAX + 1);
    localparam int MC_W    = (MC_DIV > 1) ? $clog2(MC_DIV) : 1;

    logic [MC_W-1:0]  mc_q, mc_d;
    logic             ce;
    logic             hs_edge, vs_edge, tick;
    logic [CNT_W-1:0] line;

    always_comb begin
        ce   = (mc_q == MC_W'(MC_DIV - 1));
        mc_d = ce ? '0 : mc_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mc_q <= '0;
        else        mc_q <= mc_d;
    end

    vsd_sync_edge u_hs (
        .clk(clk), .rst_n(rst_n), .raw_i(hs_in), .pol_neg_i(hs_pol_neg),
        .ce_i(ce), .edge_o(hs_edge)
    );

    vsd_sync_edge u_vs (
        .clk(clk), .rst_n(rst_n), .raw_i(vs_in), .pol_neg_i(vs_pol_neg),
        .ce_i(ce), .edge_o(vs_edge)
    );

    vsd_line_counter #(.CNT_W(CNT_W), .CNT_MAX(CNT_MAX)) u_cnt (
        .clk(clk), .rst_n(rst_n), .ce_i(ce), .vs_edge_i(vs_edge),
        .hs_edge_i(hs_edge), .tick_o(tick), .line_o(line)
    );

    for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_region
        vsd_region #(.POS_W(POS_W), .CNT_W(CNT_W)) u_reg (
            .clk(clk), .rst_n(rst_n),
            .wr_hit_i(wr_en && (wr_sel == SEL_W'(g))),
            .wr_data_i(wr_data), .vs_edge_i(vs_edge), .tick_i(tick),
            .line_i(line), .pulse_o(start_pulse[g]), .act_o(region_act[g])
        );
    end

    // R6
    frame_clears_act_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vs_edge |=> region_act == '0);
endmodule

// File: tb/tb_vstart_detect.sv
module tb_vstart_detect;
    localparam int CLK_PERIOD = 10;
    localparam int MAX_CYC    = 200000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       hs_in = 1'b0, vs_in = 1'b0;
    logic       hs_pol_neg = 1'b0, vs_pol_neg = 1'b0;
    logic       wr_en = 1'b0;
    logic [0:0] wr_sel = '0;
    logic [7:0] wr_data = '0;
    logic [1:0] start_pulse, region_act;

    vstart_detect dut (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    int    n_vec = 0, n_bad = 0;
    string cur_req = "R9";
    bit    done = 0;

    // behavioural reference state
    int m_mc, m_h1, m_h2, m_v1, m_v2, m_hp, m_vp, m_cnt, m_guard;
    int m_pos[2], m_sh[2], m_pulse[2], m_act[2];

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_mc = 0; m_h1 = 0; m_h2 = 0; m_v1 = 0; m_v2 = 0; m_hp = 0; m_vp = 0;
            m_cnt = 0; m_guard = 0;
            for (int r = 0; r < 2; r++) begin
                m_pos[r] = 0; m_sh[r] = 0; m_pulse[r] = 0; m_act[r] = 0;
            end
        end else begin
            int ce, hl, vl, vse, hse, tick, open;
            ce  = (m_mc == 3);
            hl  = m_h2 ^ int'(hs_pol_neg);
            vl  = m_v2 ^ int'(vs_pol_neg);
            vse = ce && vl && !m_vp;
            hse = ce && hl && !m_hp;
            tick = 0;
            open = (m_guard == 0);
            if (vse) begin
                m_cnt = 0; m_guard = 2;
            end else begin
                if (ce && m_guard > 0) m_guard--;
                if (hse && open && m_cnt < 272) begin tick = 1; m_cnt++; end
            end
            for (int r = 0; r < 2; r++) begin
                m_pulse[r] = 0;
                if (vse) begin m_sh[r] = m_pos[r]; m_act[r] = 0; end
                else if (tick && m_sh[r] != 0 && m_cnt == 17 + m_sh[r]) begin
                    m_pulse[r] = 1; m_act[r] = 1;
                end
                if (wr_en && int'(wr_sel) == r) m_pos[r] = int'(wr_data);
            end
            if (ce) begin m_hp = hl; m_vp = vl; end
            m_h2 = m_h1; m_h1 = int'(hs_in);
            m_v2 = m_v1; m_v1 = int'(vs_in);
            m_mc = (m_mc + 1) % 4;
        end
    end

    // per-clock comparison against the model
    always @(negedge clk) if (rst_n && !done) begin
        for (int r = 0; r < 2; r++) begin
            n_vec++;
            if (int'(start_pulse[r]) != m_pulse[r] || int'(region_act[r]) != m_act[r]) begin
                n_bad++;
                $display("FAIL %s region%0d pulse/act=%0d/%0d expected %0d/%0d at %0t",
                         cur_req, r, start_pulse[r], region_act[r], m_pulse[r], m_act[r], $time);
            end
        end
    end

    // pulse position monitor
    int lines_sent = 0;
    int pcnt[2], pline[2];
    always @(negedge clk) if (rst_n)
        for (int r = 0; r < 2; r++)
            if (start_pulse[r]) begin pcnt[r]++; pline[r] = lines_sent; end

    task automatic check(input string req, input int act, input int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic write_reg(input int r, input int v);
        @(negedge clk);
        wr_en = 1; wr_sel = 1'(r); wr_data = 8'(v);
        @(negedge clk);
        wr_en = 0;
    endtask

    // drive the normalised (active-high) level; polarity applied here
    task automatic set_hs(input bit a); hs_in = a ^ hs_pol_neg; endtask
    task automatic set_vs(input bit a); vs_in = a ^ vs_pol_neg; endtask

    task automatic frame(input int nlines, input bit early, input int wr_line,
                         input int wr_val);
        @(negedge clk);
        pcnt[0] = 0; pcnt[1] = 0; pline[0] = -1; pline[1] = -1; lines_sent = 0;
        set_vs(1);
        if (early) begin set_hs(1); lines_sent = 1; end
        wait_clk(40);
        set_vs(0); set_hs(0);
        wait_clk(40);
        for (int l = lines_sent; l < nlines; l++) begin
            set_hs(1); lines_sent++;
            wait_clk(32);
            set_hs(0);
            wait_clk(32);
            if (lines_sent == wr_line) write_reg(0, wr_val);
        end
        wait_clk(16);
    endtask

    initial begin
        #(CLK_PERIOD * MAX_CYC);
        n_bad++;
        $display("FAIL watchdog expired");
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        wait_clk(3);
        rst_n = 1;
        wait_clk(2);
        // R9
        check("R9 pulse", int'(start_pulse), 0);
        check("R9 act", int'(region_act), 0);

        // R3 / R4: independent start lines
        cur_req = "R3";
        write_reg(0, 1); write_reg(1, 5);
        frame(30, 0, -1, 0);
        check("R3 r0 line", pline[0], 18);
        check("R4 r1 line", pline[1], 22);
        check("R6 r0 one pulse", pcnt[0], 1);
        check("R6 r0 act held", int'(region_act[0]), 1);

        // R6: next frame edge clears the flag
        cur_req = "R6";
        @(negedge clk); set_vs(1); wait_clk(40); set_vs(0); wait_clk(8);
        check("R6 act cleared", int'(region_act), 0);

        // R5: zero disables region 1
        cur_req = "R5";
        write_reg(1, 0);
        frame(40, 0, -1, 0);
        check("R5 r1 pulses", pcnt[1], 0);
        check("R5 r1 act", int'(region_act[1]), 0);
        check("R5 r0 still live", pline[0], 18);

        // R8: mid-frame write deferred
        cur_req = "R8";
        write_reg(0, 3);
        frame(30, 0, 5, 10);
        check("R8 current frame", pline[0], 20);
        frame(35, 0, -1, 0);
        check("R8 next frame", pline[0], 27);

        // R7: saturation at 272
        cur_req = "R7";
        write_reg(0, 255);
        frame(300, 0, -1, 0);
        check("R7 line", pline[0], 272);
        check("R7 single pulse", pcnt[0], 1);

        // R1: negative polarity on both inputs
        cur_req = "R1";
        @(negedge clk);
        hs_pol_neg = 1; vs_pol_neg = 1; set_hs(0); set_vs(0);
        wait_clk(40);
        write_reg(0, 2); write_reg(1, 4);
        frame(30, 0, -1, 0);
        check("R1 neg r0 line", pline[0], 19);
        check("R1 neg r1 line", pline[1], 21);
        // mixed polarity
        @(negedge clk);
        vs_pol_neg = 0; set_vs(0);
        wait_clk(40);
        frame(30, 0, -1, 0);
        check("R1 mixed r0 line", pline[0], 19);

        // R2: edge coincident with frame edge is ignored
        cur_req = "R2";
        write_reg(0, 4);
        frame(30, 1, -1, 0);
        check("R2 guard r0 line", pline[0], 22);
        check("R2 one pulse", pcnt[0], 1);

        wait_clk(10);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule